// File: doc/BRIEF.md
# Real-Time Amplitude Histogrammer

This block counts how often each amplitude code occurs in a stream of samples. Every sample accepted during a run selects one bin of a dual-port RAM. The bin is read, raised by one and written back, at a rate of one sample per clock. When a sample lands in the same bin as the sample just before it, the new value is forwarded, so no count is lost to the RAM read latency. A bin that reaches its largest value stays there and does not wrap.

A run begins with a start command that latches a target sample total. The block then accepts exactly that many valid samples and ignores any that follow. Once the last increment has been written to the RAM, busy drops and done rises. Done stays high until the next start. A clear command writes zero to every bin, one bin per clock. The same clear sequence runs on its own after reset. When the block is idle, the second RAM port serves a host that reads the bins out. The block has no link to any capture path, so it can run alongside one.

Top module: `amp_histogrammer`

## Requirements
- R1: After reset, clearing_o is high and busy_o and done_o are low. When clearing_o falls, every bin reads zero.
- R2: During a run, each accepted sample with value v raises bin v by exactly one.
- R3: Samples that hit the same bin on consecutive clocks each add one. None is lost.
- R4: Valid samples that arrive while busy_o is low change no bin.
- R5: A run accepts exactly target_i valid samples, and later samples are ignored. busy_o falls and done_o rises together, after the last increment is in the RAM.
- R6: A start with target_i equal to 0 sets done_o within two clocks and counts no sample.
- R7: A bin holds at 2^COUNT_W-1 and does not wrap to zero.
- R8: A clear command given while idle holds clearing_o high for exactly 2^BIN_W clocks and leaves every bin at zero.
- R9: start_i and clear_i are ignored while busy_o or clearing_o is high.
- R10: done_o stays high until the next accepted start, and that start drops it on the next clock. A clear command does not drop it.
- R11: While the block is idle, host_rdata_o shows the bin selected by host_addr_i one clock after host_addr_i is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, which also starts a clear |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | BIN_W | Sample amplitude, used as the bin index |
| start_i | input | 1 | Start a run; taken only when idle |
| clear_i | input | 1 | Zero all bins; taken only when idle |
| target_i | input | TOTAL_W | Number of samples to accumulate, latched at start |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run complete |
| clearing_o | output | 1 | Clear sequence in progress |
| host_addr_i | input | BIN_W | Host read bin index |
| host_rdata_o | output | COUNT_W | Host read data, one clock after the address |

## Verification
If the forwarding register holds a wrong value, the bin gets a low count as soon as two samples repeat back to back. The bench sees this at the first host read after done_o. If the accepted-sample counter is wrong, done_o rises at the wrong time or the bin totals disagree with the target at the end of that same run. If the clear address counter is wrong, the measured clearing_o window is not 2^BIN_W clocks, or the next read finds a bin that is not zero. Saturation faults appear only when one bin is filled to its maximum. The bench therefore drives one bin past 2^COUNT_W-1 with a narrow count width.

// File: rtl/amp_hist_pkg.sv
package amp_hist_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_RUN   = 2'd2
  } hist_state_e;
endpackage

// File: rtl/amp_hist_dpram.sv
// Dual-port RAM shaped for block-RAM inference.
// Port A is a registered read used by the update pipeline.
// Port B writes (update or clear) or reads (host).
module amp_hist_dpram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_we) begin
      mem[b_addr] <= b_wdata;
    end
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/amp_hist_update.sv
// Two-stage read-increment-write with one forwarding register.
module amp_hist_update #(
  parameter int BIN_W   = 8,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BIN_W-1:0]   in_bin,
  output logic [BIN_W-1:0]   rd_bin,
  input  logic [COUNT_W-1:0] rd_data,
  output logic               wr_en,
  output logic [BIN_W-1:0]   wr_bin,
  output logic [COUNT_W-1:0] wr_data,
  output logic               pending
);
  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] CNT_ONE = {{(COUNT_W-1){1'b0}}, 1'b1};

  logic               s1_valid;
  logic [BIN_W-1:0]   s1_bin;
  logic               fwd_valid;
  logic [BIN_W-1:0]   fwd_bin;
  logic [COUNT_W-1:0] fwd_data;
  logic [COUNT_W-1:0] base;
  logic [COUNT_W-1:0] bumped;

  assign rd_bin = in_bin;

  // The RAM read of this bin was issued in the same clock as the previous
  // write, so it misses that write. Take the forwarded value instead.
  always_comb begin
    if (fwd_valid && (fwd_bin == s1_bin)) begin
      base = fwd_data;
    end else begin
      base = rd_data;
    end
    if (base == CNT_MAX) begin
      bumped = base;
    end else begin
      bumped = base + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_bin    <= '0;
      fwd_valid <= 1'b0;
      fwd_bin   <= '0;
      fwd_data  <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_bin    <= in_bin;
      fwd_valid <= s1_valid;
      if (s1_valid) begin
        fwd_bin  <= s1_bin;
        fwd_data <= bumped;
      end
    end
  end

  assign wr_en   = s1_valid;
  assign wr_bin  = s1_bin;
  assign wr_data = bumped;
  assign pending = s1_valid;
endmodule

// File: rtl/amp_hist_ctrl.sv
// Run/clear sequencer: sample acceptance, completion and bin sweep.
module amp_hist_ctrl
  import amp_hist_pkg::*;
#(
  parameter int BIN_W   = 8,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic [TOTAL_W-1:0] target_i,
  input  logic               smp_valid_i,
  input  logic               pipe_pending,
  output logic               accept,
  output logic               clr_we,
  output logic [BIN_W-1:0]   clr_bin,
  output logic               busy_o,
  output logic               done_o,
  output logic               clearing_o
);
  localparam logic [BIN_W-1:0]   LAST_BIN = {BIN_W{1'b1}};
  localparam logic [TOTAL_W-1:0] TOT_ONE  = {{(TOTAL_W-1){1'b0}}, 1'b1};

  hist_state_e        state;
  logic [TOTAL_W-1:0] target_q;
  logic [TOTAL_W-1:0] taken;
  logic               done_q;

  assign accept = (state == ST_RUN) && smp_valid_i && (taken != target_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CLEAR;
      clr_bin  <= '0;
      target_q <= '0;
      taken    <= '0;
      done_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          clr_bin <= clr_bin + 1'b1;
          if (clr_bin == LAST_BIN) begin
            state <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (start_i) begin
            state    <= ST_RUN;
            target_q <= target_i;
            taken    <= '0;
            done_q   <= 1'b0;
          end else if (clear_i) begin
            state   <= ST_CLEAR;
            clr_bin <= '0;
          end
        end
        ST_RUN: begin
          if (accept) begin
            taken <= taken + TOT_ONE;
          end
          if ((taken == target_q) && !pipe_pending) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign clr_we     = (state == ST_CLEAR);
  assign busy_o     = (state == ST_RUN);
  assign clearing_o = (state == ST_CLEAR);
  assign done_o     = done_q;
endmodule

// File: rtl/amp_histogrammer.sv
module amp_histogrammer #(
  parameter int BIN_W   = 8,
  parameter int COUNT_W = 32,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid_i,
  input  logic [BIN_W-1:0]   smp_data_i,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic [TOTAL_W-1:0] target_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               clearing_o,
  input  logic [BIN_W-1:0]   host_addr_i,
  output logic [COUNT_W-1:0] host_rdata_o
);
  logic               accept;
  logic               clr_we;
  logic [BIN_W-1:0]   clr_bin;
  logic               pipe_pending;
  logic [BIN_W-1:0]   rd_bin;
  logic [COUNT_W-1:0] rd_data;
  logic               pipe_we;
  logic [BIN_W-1:0]   pipe_bin;
  logic [COUNT_W-1:0] pipe_wdata;
  logic               b_we;
  logic [BIN_W-1:0]   b_addr;
  logic [COUNT_W-1:0] b_wdata;

  amp_hist_ctrl #(.BIN_W(BIN_W), .TOTAL_W(TOTAL_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .clear_i      (clear_i),
    .target_i     (target_i),
    .smp_valid_i  (smp_valid_i),
    .pipe_pending (pipe_pending),
    .accept       (accept),
    .clr_we       (clr_we),
    .clr_bin      (clr_bin),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .clearing_o   (clearing_o)
  );

  amp_hist_update #(.BIN_W(BIN_W), .COUNT_W(COUNT_W)) upd_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (accept),
    .in_bin   (smp_data_i),
    .rd_bin   (rd_bin),
    .rd_data  (rd_data),
    .wr_en    (pipe_we),
    .wr_bin   (pipe_bin),
    .wr_data  (pipe_wdata),
    .pending  (pipe_pending)
  );

  // Port B priority: the clear sweep, then update writes, then host reads.
  always_comb begin
    if (clr_we) begin
      b_we    = 1'b1;
      b_addr  = clr_bin;
      b_wdata = '0;
    end else if (pipe_we) begin
      b_we    = 1'b1;
      b_addr  = pipe_bin;
      b_wdata = pipe_wdata;
    end else begin
      b_we    = 1'b0;
      b_addr  = host_addr_i;
      b_wdata = '0;
    end
  end

  amp_hist_dpram #(.AW(BIN_W), .DW(COUNT_W)) ram_i (
    .clk     (clk),
    .a_addr  (rd_bin),
    .a_rdata (rd_data),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_rdata (host_rdata_o)
  );
endmodule

// File: rtl/amp_hist_checker.sv
module amp_hist_checker #(
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               clearing_o,
  input logic               wr_en,
  input logic [COUNT_W-1:0] wr_data
);
  // R9: a start during a clear does not launch a run
  a_r9_start_ignored_in_clear: assert property (@(posedge clk) disable iff (rst)
    (clearing_o && start_i) |=> !busy_o);

  // R10: done holds until a start command
  a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  // R5: done rises only at the end of a run
  a_r5_done_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy_o));

  // R10: a run begins only on a start command
  a_r10_run_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R1: busy, done and clearing never overlap with busy
  a_r1_state_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && (done_o || clearing_o)));

  // R7: an increment never wraps a bin back to zero
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data != '0));
endmodule

bind amp_histogrammer amp_hist_checker #(.COUNT_W(COUNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .clearing_o (clearing_o),
  .wr_en      (pipe_we),
  .wr_data    (pipe_wdata)
);

// File: tb/amp_histogrammer_tb_top.sv
module amp_histogrammer_tb_top;
  localparam int BIN_W   = 8;
  localparam int COUNT_W = 4;
  localparam int TOTAL_W = 16;
  localparam int NBINS   = 1 << BIN_W;
  localparam int CMAX    = (1 << COUNT_W) - 1;
  localparam int NVEC    = 16;
  localparam logic [7:0] VEC [NVEC] = '{
    8'h05, 8'h05, 8'h05, 8'h80, 8'hFF, 8'h00, 8'h80, 8'h05,
    8'h11, 8'h11, 8'hFF, 8'h00, 8'h7E, 8'h7F, 8'h7E, 8'h05
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_valid_i = 1'b0;
  logic [BIN_W-1:0]   smp_data_i = '0;
  logic               start_i = 1'b0;
  logic               clear_i = 1'b0;
  logic [TOTAL_W-1:0] target_i = '0;
  logic               busy_o, done_o, clearing_o;
  logic [BIN_W-1:0]   host_addr_i = '0;
  logic [COUNT_W-1:0] host_rdata_o;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  bit finished = 1'b0;
  int model [NBINS];

  always #2 clk = ~clk;

  amp_histogrammer #(.BIN_W(BIN_W), .COUNT_W(COUNT_W), .TOTAL_W(TOTAL_W)) dut_i (
    .clk(clk), .rst(rst), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .start_i(start_i), .clear_i(clear_i), .target_i(target_i),
    .busy_o(busy_o), .done_o(done_o), .clearing_o(clearing_o),
    .host_addr_i(host_addr_i), .host_rdata_o(host_rdata_o)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog (R5) actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_bin(input int a, output int v);
    @(negedge clk);
    host_addr_i = a[BIN_W-1:0];
    @(negedge clk);
    v = int'(host_rdata_o);
  endtask

  task automatic pulse_start(input int t);
    @(negedge clk);
    start_i = 1'b1;
    target_i = t[TOTAL_W-1:0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drive(input logic [7:0] v);
    smp_valid_i = 1'b1;
    smp_data_i = v;
    @(negedge clk);
  endtask

  task automatic wait_done();
    int n = 0;
    smp_valid_i = 1'b0;
    while (!done_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_clear(output int cycles);
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    cycles = 0;
    while (clearing_o && cycles < 1000) begin
      cycles++;
      @(negedge clk);
    end
    for (int i = 0; i < NBINS; i++) model[i] = 0;
  endtask

  function automatic void model_add(input int v);
    if (model[v] < CMAX) model[v] = model[v] + 1;
  endfunction

  initial begin
    int v;
    int cyc;
    for (int i = 0; i < NBINS; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(clearing_o == 1'b1, "R1 clearing after reset", int'(clearing_o), 1);
    chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    // R9: start during clear is ignored
    pulse_start(5);
    chk(busy_o == 1'b0, "R9 start during clear", int'(busy_o), 0);
    while (clearing_o) @(negedge clk);
    chk(busy_o == 1'b0, "R9 no run after clear", int'(busy_o), 0);
    read_bin(8'h00, v); chk(v == 0, "R1 bin 00 zero", v, 0);
    read_bin(8'hFF, v); chk(v == 0, "R1 bin FF zero", v, 0);
    // R4: idle samples change nothing
    drive(8'h40); drive(8'h40); drive(8'h40);
    smp_valid_i = 1'b0;
    read_bin(8'h40, v); chk(v == 0, "R4 idle samples ignored", v, 0);

    // Table-driven run: back-to-back samples, then surplus samples
    pulse_start(NVEC);
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      model_add(int'(VEC[i]));
    end
    for (int i = 0; i < 4; i++) drive(8'h33);   // R5 surplus
    wait_done();
    chk(done_o == 1'b1, "R5 done after target", int'(done_o), 1);
    chk(busy_o == 1'b0, "R5 busy low at done", int'(busy_o), 0);
    for (int b = 0; b < NBINS; b++) begin
      read_bin(b, v);
      chk(v == model[b], $sformatf("R2 bin %0d (R11 readout)", b), v, model[b]);
    end
    read_bin(8'h05, v); chk(v == 5, "R3 repeated bin 05", v, 5);
    read_bin(8'h33, v); chk(v == 0, "R5 surplus bin 33", v, 0);

    // R10: done held, and survives a clear
    repeat (10) @(negedge clk);
    chk(done_o == 1'b1, "R10 done held", int'(done_o), 1);
    do_clear(cyc);
    chk(cyc == NBINS, "R8 clear length", cyc, NBINS);
    chk(done_o == 1'b1, "R10 done kept over clear", int'(done_o), 1);
    read_bin(8'h05, v); chk(v == 0, "R8 bin 05 cleared", v, 0);
    read_bin(8'h80, v); chk(v == 0, "R8 bin 80 cleared", v, 0);

    // R9: start and clear during a run are ignored
    pulse_start(3);
    chk(done_o == 1'b0, "R10 start drops done", int'(done_o), 1'b0);
    start_i = 1'b1; clear_i = 1'b1; target_i = 16'd10;
    drive(8'h20);
    start_i = 1'b0; clear_i = 1'b0;
    for (int i = 0; i < 4; i++) drive(8'h20);
    wait_done();
    chk(clearing_o == 1'b0, "R9 clear ignored while busy", int'(clearing_o), 0);
    read_bin(8'h20, v); chk(v == 3, "R9 R5 target kept at 3", v, 3);

    // R6: zero target
    pulse_start(0);
    @(negedge clk);
    chk(done_o == 1'b1, "R6 zero target done", int'(done_o), 1);
    read_bin(8'h20, v); chk(v == 3, "R6 no sample counted", v, 3);

    // R7: saturation
    do_clear(cyc);
    pulse_start(20);
    for (int i = 0; i < 20; i++) drive(8'h09);
    wait_done();
    read_bin(8'h09, v); chk(v == CMAX, "R7 saturated bin", v, CMAX);

    // R3: gapped and alternating pattern
    do_clear(cyc);
    pulse_start(6);
    drive(8'h0A); drive(8'h0B); drive(8'h0A);
    smp_valid_i = 1'b0; @(negedge clk);
    drive(8'h0A); drive(8'h0A); drive(8'h0B);
    wait_done();
    read_bin(8'h0A, v); chk(v == 4, "R3 bin 0A mixed", v, 4);
    read_bin(8'h0B, v); chk(v == 2, "R3 bin 0B mixed", v, 2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule